// File: doc/BRIEF.md
# Firmware Window Shadowing Decoder

This block sits on a processor's physical address path and picks, for every access, whether the boot ROM or main RAM is selected, or whether the access is blocked. The boot ROM shows up in two 64 KiB windows at once. One is at the very top of the 4 GiB space, so the fetch at reset lands in firmware. The other is the legacy window at 0x000F0000. In both windows the ROM sees the low 16 address bits, so the two windows reach the same ROM bytes.

The low window covers 64 KiB of RAM, and firmware can shadow the ROM into it. Read routing and write routing for that window are set separately. Firmware first sets reads to ROM and writes to RAM, then copies the image. It then switches reads to RAM and turns on write protection. From then on, a write into the low window selects no target and raises a violation pulse. A separate bit sets the cacheable attribute of firmware-window accesses.

Decoding is combinational from the address, the direction and the configuration register. A configuration write takes effect at the next rising clock edge.

Top module: `fw_shadow_decoder`

## Requirements
- R1: After reset the configuration is all clear. A read of 0xFFFFFFF0 asserts `rom_cs`, keeps `ram_cs` low and gives `rom_addr` = 0xFFF0.
- R2: In both windows, 0xFFFF0000–0xFFFFFFFF and 0x000F0000–0x000FFFFF, `rom_addr` equals address bits 15:0. The same offset in either window gives the same `rom_addr`.
- R3: With configuration bit 0 clear, low-window reads go to the ROM. With bit 1 clear, low-window writes go to the ROM. The RAM under the low window is then not selected.
- R4: Read routing (bit 0, 1 = RAM) and write routing (bit 1, 1 = RAM) act independently. With bit 0 = 0 and bit 1 = 1, low-window reads select the ROM and low-window writes select RAM.
- R5: With bit 0 = 1, low-window reads assert `ram_cs` and keep `rom_cs` low.
- R6: With write-protect (bit 2) set, a low-window write asserts neither select. `wr_violation` is high for exactly the one cycle after each such write cycle.
- R7: `cacheable` equals configuration bit 3 for accesses in either firmware window. It is 1 for every other address.
- R8: Addresses outside both windows always assert `ram_cs`, whatever the configuration.
- R9: The top window always asserts `rom_cs`, for reads and writes, whatever the configuration.
- R10: A value written on `cfg_wdata` with `cfg_we` high takes effect only after the next rising edge. With `acc_valid` low, neither select is asserted.
- R11: `rom_cs` and `ram_cs` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 4 | Bit 0 read-to-RAM, bit 1 write-to-RAM, bit 2 write-protect, bit 3 cacheable |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Physical address |
| rom_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | Main RAM select |
| rom_addr | output | 16 | ROM-relative address |
| cacheable | output | 1 | Cache attribute of the access |
| wr_violation | output | 1 | One-cycle pulse after a blocked write |

## Verification
Two functions can meet in one cycle: a configuration write being captured, and a low-window access that is decoded under the old setting. The bench drives `cfg_we` together with a low-window write. It then checks that the write still reaches the ROM in that cycle and reaches RAM only after the edge. A second overlap is a blocked write that is followed at once by an idle cycle. The bench checks that the selects fall straight away while `wr_violation` appears one cycle later and lasts a single cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int CFG_W = 4;
  localparam int B_RD_RAM = 0;
  localparam int B_WR_RAM = 1;
  localparam int B_WPROT  = 2;
  localparam int B_CACHE  = 3;

  typedef struct packed {
    logic cache_en;
    logic wprot;
    logic wr_ram;
    logic rd_ram;
  } fw_cfg_t;

  function automatic fw_cfg_t unpack_cfg(input logic [CFG_W-1:0] v);
    fw_cfg_t c;
    c.rd_ram   = v[B_RD_RAM];
    c.wr_ram   = v[B_WR_RAM];
    c.wprot    = v[B_WPROT];
    c.cache_en = v[B_CACHE];
    return c;
  endfunction
endpackage

// File: rtl/fwd_cfg_reg.sv
module fwd_cfg_reg
  import fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output fw_cfg_t          cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) cfg <= unpack_cfg(wdata);
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
endmodule

// File: rtl/fwd_window_match.sv
module fwd_window_match #(
  parameter int          ADDR_W = 32,
  parameter int          WIN_AW = 16,
  parameter logic [31:0] BASE   = 32'h000F0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_AW;

  function automatic logic tag_eq(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] b;
    b = ADDR_W'(BASE);
    return a[ADDR_W-1:WIN_AW] == b[ADDR_W-1:WIN_AW];
  endfunction

  if (TAG_W > 0) begin : g_tag
    assign hit = tag_eq(addr);
  end else begin : g_all
    assign hit = 1'b1;
  end
endmodule

// File: rtl/fwd_route.sv
module fwd_route
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fw_cfg_t           cfg,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit_hi,
  input  logic              hit_lo,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              cacheable,
  output logic              wr_violation
);
  logic lo_to_ram, blocked_wr, in_fw, viol_q;

  function automatic logic [ROM_AW-1:0] rom_off(input logic [ADDR_W-1:0] a);
    return a[ROM_AW-1:0];
  endfunction

  always_comb begin
    in_fw      = hit_hi | hit_lo;
    lo_to_ram  = write ? cfg.wr_ram : cfg.rd_ram;
    blocked_wr = valid & write & hit_lo & cfg.wprot;
    rom_cs     = valid & (hit_hi | (hit_lo & !blocked_wr & !lo_to_ram));
    ram_cs     = valid & ((!in_fw) | (hit_lo & !blocked_wr & lo_to_ram));
    rom_addr   = rom_off(addr);
    cacheable  = in_fw ? cfg.cache_en : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= blocked_wr;
  end
  assign wr_violation = viol_q;

  p_sel_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));
  p_hi_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit_hi) |-> (rom_cs && !ram_cs));
  p_out_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !hit_hi && !hit_lo) |-> (ram_cs && !rom_cs));
  p_prot_nosel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write && hit_lo && cfg.wprot) |-> (!rom_cs && !ram_cs));
  p_prot_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write && hit_lo && cfg.wprot) |=> wr_violation);
  p_shadow_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !write && hit_lo && cfg.rd_ram) |-> (ram_cs && !rom_cs));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!rom_cs && !ram_cs));
endmodule

// File: rtl/fw_shadow_decoder.sv
module fw_shadow_decoder
  import fwd_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          ROM_AW  = 16,
  parameter logic [31:0] LO_BASE = 32'h000F0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              cacheable,
  output logic              wr_violation
);
  localparam logic [31:0] HI_BASE = 32'(~((64'd1 << ROM_AW) - 64'd1));
  localparam int          N_WIN   = 2;
  localparam logic [31:0] BASES [N_WIN] = '{HI_BASE, LO_BASE};

  fw_cfg_t           cfg;
  logic [N_WIN-1:0]  hits;

  fwd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    fwd_window_match #(.ADDR_W(ADDR_W), .WIN_AW(ROM_AW), .BASE(BASES[w])) u_m (
      .addr(acc_addr), .hit(hits[w])
    );
  end

  fwd_route #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_route (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .valid(acc_valid), .write(acc_write), .addr(acc_addr),
    .hit_hi(hits[0]), .hit_lo(hits[1]),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .rom_addr(rom_addr),
    .cacheable(cacheable), .wr_violation(wr_violation)
  );

  p_win_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));
endmodule

// File: tb/fw_shadow_decoder_tb.sv
module fw_shadow_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        rom_cs, ram_cs, cacheable, wr_violation;
  logic [15:0] rom_addr;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fw_shadow_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .rom_addr(rom_addr),
    .cacheable(cacheable), .wr_violation(wr_violation)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive an access at a falling edge and check the combinational decode
  task automatic access(input string req, input logic [31:0] a, input logic wr,
                        input logic e_rom, input logic e_ram, input logic e_cache);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    #1;
    check({req, " rom_cs"}, rom_cs, e_rom);
    check({req, " ram_cs"}, ram_cs, e_ram);
    check({req, " cacheable"}, cacheable, e_cache);
    check("R11 exclusive", rom_cs & ram_cs, 1'b0);
    if (e_rom) check({req, " rom_addr"}, rom_addr, a[15:0]);
  endtask

  task automatic set_cfg(input logic [3:0] v);
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    access("R1 reset fetch", 32'hFFFF_FFF0, 1'b0, 1, 0, 0);
    check("R1 rom_addr", rom_addr, 32'hFFF0);
    check("R6 no viol at reset", wr_violation, 0);
  endtask

  task automatic t_alias;
    logic [15:0] a, b;
    access("R2 low alias", 32'h000F_1234, 1'b0, 1, 0, 0);
    a = rom_addr;
    access("R2 high alias", 32'hFFFF_1234, 1'b0, 1, 0, 0);
    b = rom_addr;
    check("R2 same offset", a, b);
    access("R3 low read default", 32'h000F_FFFF, 1'b0, 1, 0, 0);
    access("R3 low write default", 32'h000F_0010, 1'b1, 1, 0, 0);
    @(negedge clk); acc_valid = 1'b0; #1;
    check("R10 idle rom_cs", rom_cs, 0);
    check("R10 idle ram_cs", ram_cs, 0);
  endtask

  task automatic t_outside;
    access("R8 low ram", 32'h0001_2345, 1'b0, 0, 1, 1);
    access("R8 below window", 32'h000E_FFFF, 1'b1, 0, 1, 1);
    access("R8 above window", 32'h0010_0000, 1'b0, 0, 1, 1);
    access("R8 below top", 32'hFFFE_FFFF, 1'b0, 0, 1, 1);
  endtask

  task automatic t_copy;
    // config write together with a low-window write: old routing holds this cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 4'b0010;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h000F_0100;
    #1;
    check("R10 old routing rom", rom_cs, 1);
    check("R10 old routing ram", ram_cs, 0);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    check("R10 new routing ram", ram_cs, 1);
    check("R10 new routing rom", rom_cs, 0);
    access("R4 copy read rom", 32'h000F_0100, 1'b0, 1, 0, 0);
    access("R4 copy write ram", 32'h000F_8000, 1'b1, 0, 1, 0);
  endtask

  task automatic t_shadow;
    set_cfg(4'b0111);
    access("R5 shadow read", 32'h000F_4000, 1'b0, 0, 1, 0);
    check("R6 viol idle before", wr_violation, 0);
    access("R6 blocked write", 32'h000F_4000, 1'b1, 0, 0, 0);
    @(negedge clk); acc_valid = 1'b0; #1;
    check("R6 viol pulse", wr_violation, 1);
    @(negedge clk); #1;
    check("R6 viol single cycle", wr_violation, 0);
    access("R9 top write", 32'hFFFF_0004, 1'b1, 1, 0, 0);
    access("R9 top read", 32'hFFFF_FFF0, 1'b0, 1, 0, 0);
    access("R8 outside write", 32'h0200_0000, 1'b1, 0, 1, 1);
    @(negedge clk); acc_valid = 1'b0; #1;
    check("R6 no viol after legal", wr_violation, 0);
  endtask

  task automatic t_cache;
    set_cfg(4'b1000);
    access("R7 low cacheable", 32'h000F_0000, 1'b0, 1, 0, 1);
    access("R7 top cacheable", 32'hFFFF_0000, 1'b0, 1, 0, 1);
    access("R7 outside", 32'h0000_0000, 1'b0, 0, 1, 1);
    set_cfg(4'b0000);
    access("R7 low uncacheable", 32'h000F_0000, 1'b0, 1, 0, 0);
  endtask

  initial begin
    #1;
    check("R1 reset rom_cs", rom_cs, 0);
    check("R1 reset viol", wr_violation, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alias();
    t_outside();
    t_copy();
    t_shadow();
    t_cache();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule